// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block prepares a 64-bit logical word for a shared bus whose data and flag wires are active-low, and restores the word on the receiving side. The word is cut into four 16-bit groups. For each group the transmit half counts how many wires would sit electrically low if the group went out unchanged. When that count is above half the group width, the group is sent inverted and its active-low inversion flag is pulled low. Otherwise the group goes out in normal active-low form with its flag high. The receive half reads each group's flag. A low flag means the group's wires are taken as active-high values. A high flag means they are taken as active-low values and complemented back.

A quad-pumped transfer carries four sub-phases in one common clock. The block treats every word presented with its valid strobe as a separate sub-phase and decides inversion for it alone. Both halves end in a parameter-selected output stage. That stage is either a register that loads when the strobe is high, or a plain pass-through. The group width, the word width and the stage choice are parameters, and their consistency is checked at elaboration.

Top module: `grouped_inversion_codec`

## Requirements
- R1: Inversion flag g governs data bits [16g+15:16g] only: flag 0 bits 15:0, flag 1 bits 31:16, flag 2 bits 47:32, flag 3 bits 63:48.
- R2: A logical 1 is driven as a low wire. When a group has more than 8 logical ones, its wires carry the logical bits unchanged and its flag is driven 0. Otherwise its wires carry the complement of the logical bits and its flag is driven 1.
- R3: A group with exactly 8 logical ones is not inverted (flag 1, wires are the complement of the data).
- R4: After encoding, no group drives more than 8 of its 16 data wires low.
- R5: On receive, a group whose flag wire is 0 is restored as the wire values. A group whose flag wire is 1 is restored as the complement of the wire values.
- R6: Decoding the encoder's wire and flag output reproduces the original 64-bit word exactly, for every pattern.
- R7: Each group's decision depends only on its own 16 bits, so groups in one word may be inverted independently of each other.
- R8: With the register stage, a word presented with valid high appears on the outputs after the next rising edge, with the output valid high in that cycle.
- R9: In a cycle where valid is low, the registered outputs keep their previous value and the output valid is low on the next cycle.
- R10: While reset is low, the transmit wires and flags all read 1 (bus idle), the received data reads 0 and both output valids read 0.
- R11: Words presented on consecutive cycles, as consecutive sub-phases, each receive their own inversion decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Sub-phase strobe for the transmit word |
| tx_data | input | 64 | Logical word to be sent |
| tx_out_valid | output | 1 | Encoded sub-phase valid |
| tx_wire | output | 64 | Encoded data wire levels |
| tx_flag_n | output | 4 | Active-low inversion flag per group |
| rx_valid | input | 1 | Sub-phase strobe for the received wires |
| rx_wire | input | 64 | Received data wire levels |
| rx_flag_n | input | 4 | Received active-low inversion flags |
| rx_out_valid | output | 1 | Decoded sub-phase valid |
| rx_data | output | 64 | Restored logical word |

## Verification
The encoder is driven with groups of all zeros, all ones, exactly eight ones and exactly nine ones. These separate the inverted side of the threshold from the plain side at its one-bit boundary. Words that mix those group types show that each flag follows its own bit range. The decoder is given hand-built wire and flag combinations, so it is judged apart from the encoder. Random words sent in back-to-back sub-phases and fed through both halves confirm the exact round trip. An idle cycle with changed inputs confirms the hold.

// File: rtl/inv_codec_pkg.sv
package inv_codec_pkg;
   localparam int unsigned DEF_WORD_W  = 64;
   localparam int unsigned DEF_GROUP_W = 16;

   // Count logical ones in a group slice; used for the inversion threshold.
   function automatic int unsigned ones_in(input logic [DEF_WORD_W-1:0] v, input int unsigned w);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i < DEF_WORD_W; i++)
         if (i < w && v[i]) n++;
      return n;
   endfunction
endpackage

// File: rtl/inv_group_encoder.sv
module inv_group_encoder #(
   parameter int unsigned GROUP_W = 16
) (
   input  logic [GROUP_W-1:0] data_i,
   output logic [GROUP_W-1:0] wire_o,
   output logic               inv_n_o
);
   localparam int unsigned HALF  = GROUP_W / 2;
   localparam int unsigned CNT_W = $clog2(GROUP_W + 1);

   logic [CNT_W-1:0] low_cnt;
   logic             do_inv;

   // A logical one is a low wire, so the one-count is the low-wire count.
   always_comb begin
      low_cnt = '0;
      for (int unsigned i = 0; i < GROUP_W; i++)
         low_cnt = low_cnt + CNT_W'(data_i[i]);
   end

   assign do_inv  = (low_cnt > CNT_W'(HALF));
   assign wire_o  = do_inv ? data_i : ~data_i;
   assign inv_n_o = ~do_inv;

   always_comb begin
      // R4: never more than half the wires low after encoding
      a_r4_low_limit: assert ($countones(~wire_o) <= HALF)
         else $error("group drives too many low wires");
      // R3: a group exactly at half stays uninverted
      if ($countones(data_i) == HALF)
         a_r3_tie_plain: assert (inv_n_o == 1'b1)
            else $error("tie group was inverted");
   end
endmodule

// File: rtl/inv_group_decoder.sv
module inv_group_decoder #(
   parameter int unsigned GROUP_W = 16
) (
   input  logic [GROUP_W-1:0] wire_i,
   input  logic               inv_n_i,
   output logic [GROUP_W-1:0] data_o
);
   // Low flag: wires read active high; high flag: wires read active low.
   assign data_o = inv_n_i ? ~wire_i : wire_i;
endmodule

// File: rtl/inv_out_stage.sv
module inv_out_stage #(
   parameter int unsigned W          = 68,
   parameter bit          REGISTERED = 1'b1,
   parameter logic [W-1:0] RST_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_i,
   input  logic [W-1:0] data_i,
   output logic         valid_o,
   output logic [W-1:0] data_o
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= RST_VAL;
         end else begin
            valid_o <= valid_i;
            if (valid_i) data_o <= data_i;
         end
      end

      // R8: a strobed sub-phase shows up one edge later
      a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> (valid_o && data_o == $past(data_i)))
         else $error("sub-phase not captured");
      // R9: no strobe, no change
      a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> (!valid_o && $stable(data_o)))
         else $error("output changed without strobe");
   end else begin : g_pass
      assign valid_o = valid_i;
      assign data_o  = data_i;
   end
endmodule

// File: rtl/grouped_inversion_codec.sv
module grouped_inversion_codec
   import inv_codec_pkg::*;
#(
   parameter int unsigned WORD_W  = DEF_WORD_W,
   parameter int unsigned GROUP_W = DEF_GROUP_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tx_valid,
   input  logic [WORD_W-1:0]           tx_data,
   output logic                        tx_out_valid,
   output logic [WORD_W-1:0]           tx_wire,
   output logic [WORD_W/GROUP_W-1:0]   tx_flag_n,
   input  logic                        rx_valid,
   input  logic [WORD_W-1:0]           rx_wire,
   input  logic [WORD_W/GROUP_W-1:0]   rx_flag_n,
   output logic                        rx_out_valid,
   output logic [WORD_W-1:0]           rx_data
);
   localparam int unsigned N_GRP = WORD_W / GROUP_W;
   localparam int unsigned TX_W  = WORD_W + N_GRP;

   if (GROUP_W < 2 || (WORD_W % GROUP_W) != 0) begin : g_bad_cfg
      $error("WORD_W must be a multiple of GROUP_W, GROUP_W >= 2");
   end

   logic [WORD_W-1:0] enc_wire;
   logic [N_GRP-1:0]  enc_flag_n;
   logic [WORD_W-1:0] dec_data;

   // R1, R7: one encoder and one decoder per independent group
   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      inv_group_encoder #(.GROUP_W(GROUP_W)) u_enc (
         .data_i  (tx_data[g*GROUP_W +: GROUP_W]),
         .wire_o  (enc_wire[g*GROUP_W +: GROUP_W]),
         .inv_n_o (enc_flag_n[g])
      );
      inv_group_decoder #(.GROUP_W(GROUP_W)) u_dec (
         .wire_i  (rx_wire[g*GROUP_W +: GROUP_W]),
         .inv_n_i (rx_flag_n[g]),
         .data_o  (dec_data[g*GROUP_W +: GROUP_W])
      );
   end

   logic [TX_W-1:0] tx_bundle;

   inv_out_stage #(.W(TX_W), .REGISTERED(REG_OUT), .RST_VAL({TX_W{1'b1}})) u_tx_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (tx_valid),
      .data_i  ({enc_flag_n, enc_wire}),
      .valid_o (tx_out_valid),
      .data_o  (tx_bundle)
   );
   assign tx_wire   = tx_bundle[WORD_W-1:0];
   assign tx_flag_n = tx_bundle[TX_W-1:WORD_W];

   inv_out_stage #(.W(WORD_W), .REGISTERED(REG_OUT), .RST_VAL({WORD_W{1'b0}})) u_rx_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (rx_valid),
      .data_i  (dec_data),
      .valid_o (rx_out_valid),
      .data_o  (rx_data)
   );

   // R6: the encoder output, read back by the receive rule, gives the input word
   always_comb begin
      if (rst_n) begin
         for (int g = 0; g < N_GRP; g++) begin
            a_r6_roundtrip: assert ((enc_flag_n[g] ? ~enc_wire[g*GROUP_W +: GROUP_W]
                                                   :  enc_wire[g*GROUP_W +: GROUP_W])
                                    == tx_data[g*GROUP_W +: GROUP_W])
               else $error("encoded group does not restore");
         end
      end
   end
endmodule

// File: tb/grouped_inversion_codec_bench.sv
module grouped_inversion_codec_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_valid = 1'b0;
   logic [63:0] tx_data = '0;
   logic        tx_out_valid;
   logic [63:0] tx_wire;
   logic [3:0]  tx_flag_n;
   logic        rx_valid = 1'b0;
   logic [63:0] rx_wire = '1;
   logic [3:0]  rx_flag_n = '1;
   logic        rx_out_valid;
   logic [63:0] rx_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;  // 50 MHz

   grouped_inversion_codec u_grouped_inversion_codec (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_out_valid(tx_out_valid), .tx_wire(tx_wire), .tx_flag_n(tx_flag_n),
      .rx_valid(rx_valid), .rx_wire(rx_wire), .rx_flag_n(rx_flag_n),
      .rx_out_valid(rx_out_valid), .rx_data(rx_data)
   );

   task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected encoding from R2: >8 ones -> send as-is, flag 0; else complement, flag 1.
   function automatic logic [67:0] model_enc(input logic [63:0] d);
      logic [63:0] w;
      logic [3:0]  f;
      for (int g = 0; g < 4; g++) begin
         int n;
         n = 0;
         for (int b = 0; b < 16; b++) n += int'(d[g*16+b]);
         if (n > 8) begin w[g*16 +: 16] = d[g*16 +: 16];  f[g] = 1'b0; end
         else       begin w[g*16 +: 16] = ~d[g*16 +: 16]; f[g] = 1'b1; end
      end
      return {f, w};
   endfunction

   function automatic logic [63:0] model_dec(input logic [63:0] w, input logic [3:0] f);
      logic [63:0] d;
      for (int g = 0; g < 4; g++)
         d[g*16 +: 16] = f[g] ? ~w[g*16 +: 16] : w[g*16 +: 16];
      return d;
   endfunction

   task automatic send_tx(input string req, input logic [63:0] d);
      @(negedge clk);
      tx_valid = 1'b1; tx_data = d;
      @(negedge clk);
      tx_valid = 1'b0;
      check({req, " tx"}, {tx_flag_n, tx_wire}, model_enc(d));
      check({req, " txv"}, 68'(tx_out_valid), 68'(1));
   endtask

   task automatic t_reset();
      // R10
      check("R10 wire", 68'(tx_wire), 68'({64{1'b1}}));
      check("R10 flag", 68'(tx_flag_n), 68'(4'hF));
      check("R10 rxd", 68'(rx_data), 68'(0));
      check("R10 valids", 68'({tx_out_valid, rx_out_valid}), 68'(0));
   endtask

   task automatic t_threshold();
      logic [67:0] e;
      send_tx("R2 zeros", 64'h0);
      send_tx("R2 ones", {64{1'b1}});
      // R3: exactly 8 ones in each group -> not inverted
      send_tx("R3 tie", 64'h00FF_0F0F_5555_F00F);
      check("R3 flag", 68'(tx_flag_n), 68'(4'hF));
      // 9 ones in each group -> inverted, flags 0
      send_tx("R2 nine", 64'h01FF_1F0F_5557_F01F);
      check("R2 flag", 68'(tx_flag_n), 68'(4'h0));
      // R4: low-wire count never above 8 per group
      for (int g = 0; g < 4; g++)
         check("R4 lowcnt", 68'($countones(~tx_wire[g*16 +: 16]) <= 8), 68'(1));
      // R1, R7: mix: group0 nine, group1 eight, group2 all ones, group3 zero
      send_tx("R1 mix", 64'h0000_FFFF_00FF_01FF);
      check("R7 mixflags", 68'(tx_flag_n), 68'(4'b1010));
      e = model_enc(64'h0000_FFFF_00FF_01FF);
      check("R1 grp2 wires", 68'(tx_wire[47:32]), 68'(e[47:32]));
   endtask

   task automatic recv(input string req, input logic [63:0] w, input logic [3:0] f, input logic [63:0] exp);
      @(negedge clk);
      rx_valid = 1'b1; rx_wire = w; rx_flag_n = f;
      @(negedge clk);
      rx_valid = 1'b0;
      check(req, 68'(rx_data), 68'(exp));
      check({req, " v"}, 68'(rx_out_valid), 68'(1));
   endtask

   task automatic t_decode();
      // R5: flag 0 -> wire as-is; flag 1 -> complement
      recv("R5 allplain", 64'h1234_5678_9ABC_DEF0, 4'hF, ~64'h1234_5678_9ABC_DEF0);
      recv("R5 allinv", 64'h1234_5678_9ABC_DEF0, 4'h0, 64'h1234_5678_9ABC_DEF0);
      recv("R5 R1 flag2", 64'h0, 4'b1011, 64'hFFFF_0000_FFFF_FFFF);
   endtask

   task automatic t_hold();
      logic [67:0] held;
      send_tx("R9 prime", 64'hAAAA_0001_FFFE_7777);
      held = {tx_flag_n, tx_wire};
      @(negedge clk);
      tx_data = 64'h5555_5555_0000_1111;  // valid stays low
      @(negedge clk);
      check("R9 hold", {tx_flag_n, tx_wire}, held);
      check("R9 novalid", 68'(tx_out_valid), 68'(0));
   endtask

   task automatic t_subphases();
      // R11, R8: four back-to-back sub-phases, each checked the cycle after
      logic [63:0] ph [4];
      ph[0] = 64'h0;  ph[1] = {64{1'b1}};
      ph[2] = 64'h00FF_01FF_00FF_01FF;  ph[3] = 64'hFFFF_0000_0180_7FFF;
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         tx_valid = 1'b1; tx_data = ph[p];
         @(negedge clk);
         check("R11 phase", {tx_flag_n, tx_wire}, model_enc(ph[p]));
         check("R8 valid", 68'(tx_out_valid), 68'(1));
      end
      tx_valid = 1'b0;
   endtask

   task automatic t_roundtrip();
      // R6: random words through encoder then decoder
      for (int k = 0; k < 40; k++) begin
         logic [63:0] d;
         d = {$urandom, $urandom};
         if (k % 4 == 1) d = d | 64'hF0F0_FF00_FFF0_0FFF;
         if (k % 4 == 2) d = d & 64'h0101_0F00_1000_0001;
         @(negedge clk);
         tx_valid = 1'b1; tx_data = d;
         @(negedge clk);
         tx_valid = 1'b0;
         rx_valid = 1'b1; rx_wire = tx_wire; rx_flag_n = tx_flag_n;
         check("R2 rand", {tx_flag_n, tx_wire}, model_enc(d));
         @(negedge clk);
         rx_valid = 1'b0;
         check("R6 roundtrip", 68'(rx_data), 68'(d));
         check("R6 model", 68'(model_dec(tx_wire, tx_flag_n)), 68'(d));
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_threshold();
      t_decode();
      t_hold();
      t_subphases();
      t_roundtrip();
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule